// File: doc/BRIEF.md
# Sector-granular FIFO almost-full flag

This block drives a FIFO's almost-full indication from logic that sits beside the FIFO memory. It does not depend on the memory's own flags. It runs entirely on the write clock. It takes the write-side word count and a 4-bit reflected-binary Gray code of the read position, which the read clock domain supplies. The address space is treated as sixteen equal sectors, so the flag has a resolution of one sector, which is depth/16 words.

The write sector is the top four bits of the write count. On every write-clock edge the block forms the Gray codes of that sector advanced by one, two and three places, wrapping modulo 16. Two flip-flop stages bring the read Gray code into the write domain. Each advanced code is compared against it as two 2-bit halves, and each half is registered. The halves are then joined into a registered match for each offset, and the three matches are ORed into the flag. Every stage holds its state while its clock is stopped, so the flag stays meaningful when either clock pauses.

Top module: `sector_af_gen`

## Requirements
- R1: Only the top four bits of `wr_count` (bits CNT_W-1 down to CNT_W-4) set the write sector. Changing the lower bits has no effect on `almost_full`.
- R2: With the inputs steady, `almost_full` is 1 exactly when (read sector − write sector) mod 16 is 1, 2 or 3. The read sector is the binary value of `rd_sector_gray`.
- R3: The sector distance wraps modulo 16. For example, write sector 15 with read sector 0 asserts the flag, and so does write sector 14 with read sector 1.
- R4: `almost_full` is 0 when the read sector equals the write sector, and when the distance is 4 through 15.
- R5: While `rst` is high, `almost_full` is 0 at once, because the reset is asynchronous. After `rst` falls, the flag stays 0 for at least the first two write-clock edges.
- R6: A change of write sector reaches `almost_full` on the third write-clock edge after it is applied. A change of `rd_sector_gray` reaches it on the fourth edge.
- R7: `rd_sector_gray` is sampled only through a two-stage synchronizer on the write clock. While the read side holds its code (read clock stopped), the flag does not move.
- R8: While the write clock is stopped, `almost_full` holds its value whatever the inputs do. Once the clock restarts, the flag reflects the current inputs.
- R9: Codes use the reflected binary Gray code g = b ^ (b >> 1). The three advanced codes formed for adjacent offsets differ in exactly one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rst | input | 1 | Asynchronous active-high reset |
| wr_count | input | CNT_W | Write-side word count; the top 4 bits are the write sector |
| rd_sector_gray | input | 4 | Gray-coded read sector from the read clock domain |
| almost_full | output | 1 | Registered almost-full flag |

## Verification
The bench builds the block with DEPTH = 256 and an 8-bit count. This makes the sector field bits 7:4 and leaves a 4-bit low field, so sweeping every lower-bit value under a fixed sector takes only sixteen cycles. The small count lets the vector table reach every wrap case near sector 15 and every distance class from 0 to 15 directly. A read clock running at a different period can be stopped independently of the write clock, so both frozen-clock conditions are observable at the flag.

// File: rtl/sector_af_gen.sv
module sector_af_gen #(
  parameter int DEPTH = 512,
  parameter int CNT_W = $clog2(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] wr_count,
  input  logic [3:0]       rd_sector_gray,
  output logic             almost_full
);
  localparam int SEC_W   = 4;
  localparam int SEC_LSB = CNT_W - SEC_W;
  localparam int NOFF    = 3;
  localparam logic [SEC_W-1:0] PRESET = '1;

  function automatic logic [SEC_W-1:0] to_gray(input logic [SEC_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [SEC_W-1:0] wr_sector;
  logic [SEC_W-1:0] rd_meta_q, rd_sync_q;
  logic [SEC_W-1:0] gp_q [NOFF];
  logic [NOFF-1:0]  lo_eq_q, hi_eq_q, match_q;

  assign wr_sector = wr_count[CNT_W-1:SEC_LSB];

  generate
    if (SEC_LSB > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^wr_count[SEC_LSB-1:0];
    end
  endgenerate

  always_ff @(posedge wr_clk or posedge rst) begin
    if (rst) begin
      rd_meta_q <= '0;
      rd_sync_q <= '0;
    end else begin
      rd_meta_q <= rd_sector_gray;
      rd_sync_q <= rd_meta_q;
    end
  end

  generate
    for (genvar k = 0; k < NOFF; k++) begin : g_off
      always_ff @(posedge wr_clk or posedge rst) begin
        if (rst) begin
          gp_q[k]    <= PRESET;
          lo_eq_q[k] <= 1'b0;
          hi_eq_q[k] <= 1'b0;
          match_q[k] <= 1'b0;
        end else begin
          gp_q[k]    <= to_gray(wr_sector + SEC_W'(k + 1));
          lo_eq_q[k] <= (gp_q[k][1:0] == rd_sync_q[1:0]);
          hi_eq_q[k] <= (gp_q[k][3:2] == rd_sync_q[3:2]);
          match_q[k] <= lo_eq_q[k] & hi_eq_q[k];
        end
      end
    end
  endgenerate

  assign almost_full = |match_q;
endmodule

// File: rtl/sector_af_gen_chk.sv
module sector_af_gen_chk #(
  parameter int CNT_W = 9
) (
  input logic             wr_clk,
  input logic             rst,
  input logic [CNT_W-1:0] wr_count,
  input logic [3:0]       rd_sector_gray,
  input logic             almost_full,
  input logic [3:0]       gp [3]
);
  logic [2:0] seen;
  logic [3:0] wsec;
  assign wsec = wr_count[CNT_W-1:CNT_W-4];

  function automatic logic [3:0] g2b(input logic [3:0] g);
    logic [3:0] b;
    b[3] = g[3];
    for (int i = 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic near(input logic [3:0] w, input logic [3:0] r);
    logic [3:0] d;
    d = r - w;
    return (d >= 4'd1) && (d <= 4'd3);
  endfunction

  always_ff @(posedge wr_clk or posedge rst) begin
    if (rst) seen <= '0;
    else if (seen != 3'd7) seen <= seen + 3'd1;
  end

  always @(posedge wr_clk) begin
    if (rst) AST_AF_LOW_IN_RESET: assert (!almost_full); // R5
  end

  AST_AF_MATCHES_DISTANCE: assert property (@(posedge wr_clk) disable iff (rst)
    (seen >= 3'd5) |-> (almost_full == near($past(wsec, 3), g2b($past(rd_sector_gray, 4))))); // R2, R3, R6

  AST_AF_OFF_WHEN_EQUAL: assert property (@(posedge wr_clk) disable iff (rst)
    ((seen >= 3'd5) && ($past(wsec, 3) == g2b($past(rd_sector_gray, 4)))) |-> !almost_full); // R4

  AST_GRAY_NEIGHBOURS: assert property (@(posedge wr_clk) disable iff (rst)
    (seen >= 3'd1) |-> ($onehot(gp[0] ^ gp[1]) && $onehot(gp[1] ^ gp[2]))); // R9
endmodule

bind sector_af_gen sector_af_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .wr_clk(wr_clk), .rst(rst), .wr_count(wr_count),
  .rd_sector_gray(rd_sector_gray), .almost_full(almost_full), .gp(gp_q)
);

// File: tb/sector_af_gen_tb_top.sv
module sector_af_gen_tb_top;
  localparam int DEPTH = 256;
  localparam int CNT_W = 8;
  localparam int NV    = 16;
  localparam logic [12:0] VEC [NV] = '{
    {8'h00, 4'd0,  1'b0}, {8'h00, 4'd1,  1'b1}, {8'h05, 4'd2,  1'b1}, {8'h0F, 4'd3,  1'b1},
    {8'h00, 4'd4,  1'b0}, {8'hF0, 4'd0,  1'b1}, {8'hF3, 4'd2,  1'b1}, {8'hFF, 4'd3,  1'b0},
    {8'h70, 4'd7,  1'b0}, {8'h70, 4'd6,  1'b0}, {8'h75, 4'd10, 1'b1}, {8'h7A, 4'd11, 1'b0},
    {8'hE0, 4'd1,  1'b1}, {8'h30, 4'd5,  1'b1}, {8'h9C, 4'd8,  1'b0}, {8'hC4, 4'd0,  1'b0}
  };

  logic wr_clk = 0, rd_clk = 0, rst = 1, wr_run = 1, rd_run = 1;
  logic [CNT_W-1:0] wr_count = '0;
  logic [3:0] rd_target = '0, rd_gray_q = '0;
  logic almost_full;
  int checks = 0, fails = 0;

  always begin #10; if (wr_run) wr_clk = ~wr_clk; end
  always begin #15; if (rd_run) rd_clk = ~rd_clk; end
  always @(posedge rd_clk) rd_gray_q <= rd_target ^ (rd_target >> 1);

  sector_af_gen #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .wr_clk(wr_clk), .rst(rst), .wr_count(wr_count),
    .rd_sector_gray(rd_gray_q), .almost_full(almost_full)
  );

  task automatic check(input logic got, input logic exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: almost_full=%0b expected %0b", tag, what, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge wr_clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL R6 watchdog expired: almost_full=%0b expected run end", almost_full);
    finish_run();
  end

  initial begin
    #35;
    check(almost_full, 1'b0, "R5", "during reset");
    @(negedge wr_clk) rst = 0;
    settle(8);
    check(almost_full, 1'b0, "R5", "after release, sectors equal");

    for (int i = 0; i < NV; i++) begin
      logic [3:0] ws;
      wr_count  = VEC[i][12:5];
      rd_target = VEC[i][4:1];
      ws = VEC[i][12:9];
      settle(8);
      if (!VEC[i][0]) check(almost_full, 1'b0, "R4", $sformatf("vector %0d", i));
      else if (ws > rd_target) check(almost_full, 1'b1, "R3", $sformatf("vector %0d", i));
      else check(almost_full, 1'b1, "R2", $sformatf("vector %0d", i));
    end

    wr_count = 8'h10; rd_target = 4'd3;
    settle(8);
    for (int i = 0; i < 16; i++) begin
      wr_count = CNT_W'(8'h10 | i);
      @(negedge wr_clk);
      check(almost_full, 1'b1, "R1", $sformatf("low bits %0d", i));
    end

    wr_count = 8'h40;
    settle(2);
    check(almost_full, 1'b1, "R6", "two edges after write change");
    settle(1);
    check(almost_full, 1'b0, "R6", "three edges after write change");

    wr_run = 0;
    rd_target = 4'd5;
    #400;
    check(almost_full, 1'b0, "R8", "write clock stopped");
    wr_run = 1;
    settle(8);
    check(almost_full, 1'b1, "R8", "write clock restarted");

    rd_run = 0;
    rd_target = 4'd9;
    settle(10);
    check(almost_full, 1'b1, "R7", "read clock stopped");
    rd_run = 1;
    settle(8);
    check(almost_full, 1'b0, "R7", "read clock restarted");

    rd_target = 4'd6;
    settle(8);
    check(almost_full, 1'b1, "R2", "distance two before reset");
    rst = 1;
    #1;
    check(almost_full, 1'b0, "R5", "asynchronous clear");
    @(negedge wr_clk) rst = 0;
    settle(1);
    check(almost_full, 1'b0, "R5", "first edge after release");
    settle(8);
    check(almost_full, 1'b1, "R5", "recovered after reset");

    finish_run();
  end
endmodule